// File: doc/BRIEF.md
# Boot-Mode Latch and Interrupt Promotion Register

This block is an 8-bit control register on a microcontroller's internal bus. While reset is held, it follows two mode-select pins. When reset is released it keeps the boot mode they select: a special-mode flag, a mode-A flag, a boot-ROM select and a read-visibility/clock-enable control. After that it keeps a 4-bit selector that names the one maskable interrupt source to be moved to the top of the priority order. The interrupt arbiter and the memory map read these outputs. They are not part of this block.

Software reaches the register through a chip-select from a single address decode, read and write strobes, and 8-bit write and read data. Each field has its own write rule. The two mode flags are fixed after reset. The boot-ROM select can change only in the special modes. The priority selector can change only while the CPU's interrupt-mask flag is set. The visibility control can be written at any time.

Top module: `hprio_reg`

## Requirements
- R1: Reset is synchronous and active low (`rst_n`). At each clock edge with `rst_n` low, `special_mode` loads the inverse of `mode_b_pin` and `mode_a` loads `mode_a_pin`. Once `rst_n` is high, pin changes have no effect on either flag.
- R2: Pin decode, with `mode_b_pin`,`mode_a_pin` written as B,A: 1,0 is single-chip, 1,1 is expanded, 0,0 is bootstrap and 0,1 is special test. The register image after reset is 8'h06 for single-chip, 8'h26 for expanded, 8'hC6 for bootstrap and 8'h76 for special test.
- R3: Image layout: bit 7 is `boot_rom`, bit 6 is `special_mode`, bit 5 is `mode_a`, bit 4 is `rd_vis`, and bits 3..0 are `prio_sel`. After reset, `prio_sel` is 4'b0110 in every mode.
- R4: If `reg_sel` and `rd_en` are both high at a clock edge, `rdata` shows the register image from before that edge, starting one cycle later. At all other times `rdata` holds its value, and it resets to 0.
- R5: A write is `reg_sel` and `wr_en` both high at a clock edge. `prio_sel` takes `wdata[3:0]` on a write only if `irq_mask` is 1. If `irq_mask` is 0 it is left unchanged.
- R6: `boot_rom` takes `wdata[7]` on a write only while `special_mode` is 1. While `special_mode` is 0, the write leaves it at 0.
- R7: `rd_vis` takes `wdata[4]` on every write.
- R8: Bus writes never change `special_mode` or `mode_a`. Strobes without `reg_sel` change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are latched while it is low |
| mode_a_pin | input | 1 | Mode-select pin A |
| mode_b_pin | input | 1 | Mode-select pin B |
| irq_mask | input | 1 | CPU interrupt-mask flag (1 = maskable interrupts disabled) |
| reg_sel | input | 1 | Address decode hit for this register |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| boot_rom | output | 1 | Boot-ROM select |
| special_mode | output | 1 | Special-mode flag |
| mode_a | output | 1 | Mode-A flag |
| rd_vis | output | 1 | Read-visibility / clock-enable control |
| prio_sel | output | 4 | Promoted interrupt source selector |

## Verification
A write updates the field outputs at the clock edge that samples the strobe. The bench therefore checks them on the next falling edge. Read data arrives one edge after the read strobe, so the bench issues the read, waits one rising edge, and compares `rdata` on the following falling edge. Reset images are checked on the first falling edge after `rst_n` goes high. The bench drives all inputs on falling edges, so no check races a register update.

// File: rtl/hprio_pkg.sv
package hprio_pkg;
    localparam int DATA_W = 8;
    localparam int PSEL_W = 4;

    typedef struct packed {
        logic              boot;
        logic              spec;
        logic              moda;
        logic              vis;
        logic [PSEL_W-1:0] psel;
    } hprio_img_t;
endpackage

// File: rtl/hprio_mode_decode.sv
module hprio_mode_decode
    import hprio_pkg::*;
#(
    parameter logic [PSEL_W-1:0] RST_PSEL = 4'b0110
) (
    input  logic       pin_a,
    input  logic       pin_b,
    output hprio_img_t rst_img
);
    logic is_special;
    logic is_boot;
    logic is_test;

    always_comb begin
        is_special    = ~pin_b;
        is_boot       = is_special & ~pin_a;
        is_test       = is_special & pin_a;
        rst_img.boot  = is_boot;
        rst_img.spec  = is_special;
        rst_img.moda  = pin_a;
        rst_img.vis   = is_test;
        rst_img.psel  = RST_PSEL;
    end
endmodule

// File: rtl/hprio_reg_core.sv
module hprio_reg_core
    import hprio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  hprio_img_t        rst_img,
    input  logic              wr_hit,
    input  logic              irq_mask,
    input  logic [DATA_W-1:0] wdata,
    output hprio_img_t        img
);
    hprio_img_t img_d, img_q;
    hprio_img_t wr_img;

    always_comb begin
        wr_img = hprio_img_t'(wdata);
        img_d  = img_q;
        if (wr_hit) begin
            img_d.vis = wr_img.vis;
            if (irq_mask)
                img_d.psel = wr_img.psel;
            if (img_q.spec)
                img_d.boot = wr_img.boot;
        end
        if (!img_q.spec)
            img_d.boot = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            img_q <= rst_img;
        else
            img_q <= img_d;
    end

    assign img = img_q;
endmodule

// File: rtl/hprio_read_port.sv
module hprio_read_port
    import hprio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit,
    input  hprio_img_t        img,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_hit)
            rdata_d = DATA_W'(img);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else
            rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/hprio_reg.sv
module hprio_reg
    import hprio_pkg::*;
#(
    parameter logic [PSEL_W-1:0] RST_PSEL = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_a_pin,
    input  logic              mode_b_pin,
    input  logic              irq_mask,
    input  logic              reg_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              boot_rom,
    output logic              special_mode,
    output logic              mode_a,
    output logic              rd_vis,
    output logic [PSEL_W-1:0] prio_sel
);
    hprio_img_t rst_img;
    hprio_img_t img;
    logic       wr_hit;
    logic       rd_hit;

    assign wr_hit = reg_sel & wr_en;
    assign rd_hit = reg_sel & rd_en;

    hprio_mode_decode #(.RST_PSEL(RST_PSEL)) u_decode (
        .pin_a   (mode_a_pin),
        .pin_b   (mode_b_pin),
        .rst_img (rst_img)
    );

    hprio_reg_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_img  (rst_img),
        .wr_hit   (wr_hit),
        .irq_mask (irq_mask),
        .wdata    (wdata),
        .img      (img)
    );

    hprio_read_port u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (rd_hit),
        .img    (img),
        .rdata  (rdata)
    );

    assign boot_rom     = img.boot;
    assign special_mode = img.spec;
    assign mode_a       = img.moda;
    assign rd_vis       = img.vis;
    assign prio_sel     = img.psel;
endmodule

// File: rtl/hprio_reg_checker.sv
module hprio_reg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_a_pin,
    input logic       mode_b_pin,
    input logic       irq_mask,
    input logic       reg_sel,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       boot_rom,
    input logic       special_mode,
    input logic       mode_a,
    input logic       rd_vis,
    input logic [3:0] prio_sel
);
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(special_mode) && $stable(mode_a)); // R1

    AST_RESET_LOAD: assert property (@(posedge clk)
        !rst_n |=> special_mode == !$past(mode_b_pin) && mode_a == $past(mode_a_pin)
                   && prio_sel == 4'b0110); // R2

    AST_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel && rd_en |=> rdata == {$past(boot_rom), $past(special_mode),
                                       $past(mode_a), $past(rd_vis), $past(prio_sel)}); // R4

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && rd_en) |=> $stable(rdata)); // R4

    AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel && wr_en && !irq_mask |=> $stable(prio_sel)); // R5

    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel && wr_en && irq_mask |=> prio_sel == $past(wdata[3:0])); // R5

    AST_BOOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !special_mode |-> !boot_rom); // R6

    AST_VIS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel && wr_en |=> rd_vis == $past(wdata[4])); // R7

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && wr_en) |=> $stable(prio_sel) && $stable(rd_vis) && $stable(boot_rom)); // R8
endmodule

bind hprio_reg hprio_reg_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_a_pin   (mode_a_pin),
    .mode_b_pin   (mode_b_pin),
    .irq_mask     (irq_mask),
    .reg_sel      (reg_sel),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .rdata        (rdata),
    .boot_rom     (boot_rom),
    .special_mode (special_mode),
    .mode_a       (mode_a),
    .rd_vis       (rd_vis),
    .prio_sel     (prio_sel)
);

// File: tb/hprio_reg_test.sv
module hprio_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_a_pin = 1'b0;
    logic       mode_b_pin = 1'b1;
    logic       irq_mask = 1'b0;
    logic       reg_sel = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       boot_rom, special_mode, mode_a, rd_vis;
    logic [3:0] prio_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hprio_reg uut (
        .clk(clk), .rst_n(rst_n), .mode_a_pin(mode_a_pin), .mode_b_pin(mode_b_pin),
        .irq_mask(irq_mask), .reg_sel(reg_sel), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .boot_rom(boot_rom), .special_mode(special_mode),
        .mode_a(mode_a), .rd_vis(rd_vis), .prio_sel(prio_sel)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {boot_rom, special_mode, mode_a, rd_vis, prio_sel};
    endfunction

    task automatic bus_write(input logic [7:0] d, input logic sel);
        reg_sel = sel; wr_en = 1'b1; wdata = d;
        @(posedge clk); @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_read(output logic [7:0] d);
        reg_sel = 1'b1; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_sel = 1'b0; rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] exp;
        for (int m = 0; m < 4; m++) begin
            logic pb, pa, spec;
            pb = m[1]; pa = m[0];
            spec = ~pb;
            @(negedge clk);
            rst_n = 1'b0; mode_b_pin = pb; mode_a_pin = pa; irq_mask = 1'b0;
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            // R2/R3: reset image by mode; rdata reset 0 (R4)
            case ({pb, pa})
                2'b10: exp = 8'h06;
                2'b11: exp = 8'h26;
                2'b00: exp = 8'hC6;
                default: exp = 8'h76;
            endcase
            chk("R2 reset image", outs(), exp);
            chk("R4 rdata reset", rdata, 8'h00);
            bus_read(rd);
            chk("R3 read of reset image", rd, exp);
            // R1: pins changing after reset have no effect
            mode_b_pin = ~pb; mode_a_pin = ~pa;
            repeat (2) @(negedge clk);
            chk("R1 flags held", {6'b0, special_mode, mode_a}, {6'b0, spec, pa});
            // R8: strobe without select does nothing
            irq_mask = 1'b1;
            bus_write(~exp, 1'b0);
            chk("R8 unselected write", outs(), exp);
            // R4: rdata holds with no read strobe
            chk("R4 rdata hold", rdata, exp);
            for (int mk = 0; mk < 2; mk++) begin
                for (int v = 0; v < 256; v++) begin
                    logic [7:0] w;
                    logic [7:0] prev;
                    w = v[7:0];
                    prev = exp;
                    irq_mask = mk[0];
                    bus_write(w, 1'b1);
                    exp[7]   = spec ? w[7] : 1'b0;          // R6
                    exp[6]   = spec;                          // R8
                    exp[5]   = pa;                            // R8
                    exp[4]   = w[4];                          // R7
                    exp[3:0] = mk[0] ? w[3:0] : prev[3:0];    // R5
                    chk(mk[0] ? "R5 R6 R7 write unmasked-sel" : "R5 R6 R7 write locked-sel",
                        outs(), exp);
                    bus_read(rd);
                    chk("R4 read after write", rd, exp);
                end
            end
            // R4: read concurrent with write returns pre-write image
            irq_mask = 1'b1;
            reg_sel = 1'b1; rd_en = 1'b1; wr_en = 1'b1; wdata = ~exp;
            @(posedge clk); @(negedge clk);
            reg_sel = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
            chk("R4 read-during-write old value", rdata, exp);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule